// File: doc/BRIEF.md
# Write-Back Cache Snoop Responder

This block answers bus snoops on behalf of a small direct-mapped write-back cache whose lines carry one of four coherence states: Modified, Exclusive, Shared or Invalid. Each memory read or memory write seen on the shared bus is captured and its line address is looked up in the tag and state array. Two cycles after capture the block drives a two-wire, active-low snoop answer and changes the state of the line. A clean line answers a read with a clean hit and drops to Shared. A clean line hit by a write is invalidated and reports a miss, because the cache cannot absorb another agent's write data. A dirty line reports a modified hit on either kind of snoop and is copied into a one-entry writeback buffer. The buffered line goes out only after the memory controller asks for it.

The cache's own activity reaches the array through two local inputs. A fill installs a line in Exclusive when the combined bus snoop answer was a miss, and in Shared when any other agent reported a hit of either kind. A local store makes an Exclusive or Modified line Modified. The data array sits outside the block: the block presents the set index it is looking up and captures the line presented back in the same cycle. A snoop state update wins over a local update to the same set in the same cycle. While a snoop is in flight, or while the buffer holds an unsent line, the block back-pressures the bus with a stall output.

Top module: `snp_responder`

## Requirements
- R1: After reset both snoop outputs are high, the stall and the data-phase valid are low, and every line is Invalid, so the first snoop to any address reports a miss.
- R2: The snoop answer encodes a miss as both outputs high, a clean hit as only `snp_hit_n` low, and a modified hit as only `snp_hitm_n` low. The two outputs are never low together.
- R3: A request is taken on a clock edge where `req_valid` is high, `req_stall` is low and `req_cmd` is 2'b01 (memory read) or 2'b10 (memory write). Its answer appears for exactly one cycle, starting at the second edge after the edge that took it. At all other times both outputs are high. `req_stall` is high from the taking edge until that answer edge.
- R4: Requests with `req_cmd` 2'b00 or 2'b11 produce no answer, raise no stall and leave every line state unchanged.
- R5: A read snoop hitting an Exclusive or Shared line reports a clean hit and leaves the line Shared. A read snoop to an Invalid line, or to an index holding a different tag, reports a miss and changes nothing.
- R6: A read snoop hitting a Modified line reports a modified hit, moves the line to Shared and places the line data in the writeback buffer.
- R7: A write snoop hitting an Exclusive or Shared line invalidates it and reports a miss.
- R8: A write snoop hitting a Modified line reports a modified hit, invalidates the line and places the line data in the writeback buffer.
- R9: The buffer captures `arr_data` in the lookup cycle, while `arr_idx` shows the snooped set. While the buffer is full, `req_stall` stays high and `dp_valid` stays low. After the first edge at which `mc_rdy` is high with the buffer full, `dp_valid` is high for one cycle with the buffered line on `dp_data`, and the buffer is then empty.
- R10: `lcl_fill` installs the tag of `lcl_addr` in its set. The state is Exclusive when `bus_hit_n` and `bus_hitm_n` are both high, and Shared otherwise.
- R11: `lcl_wr` to a line held in Exclusive or Modified makes it Modified. A store that hits a Shared line, or that misses, changes nothing. If both local inputs are high, the fill is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Bus transaction present |
| req_cmd | input | 2 | Transaction type: 01 memory read, 10 memory write, others ignored |
| req_addr | input | ADDR_W | Line address of the transaction (upper bits tag, lower bits set) |
| req_stall | output | 1 | New transactions are not taken while high |
| snp_hit_n | output | 1 | Active-low clean-hit answer |
| snp_hitm_n | output | 1 | Active-low modified-hit answer |
| arr_idx | output | log2(SETS) | Set index being looked up, for the external data array |
| arr_data | input | LINE_W | Line data returned by the external data array for `arr_idx` |
| mc_rdy | input | 1 | Memory controller asks for the buffered dirty line |
| dp_valid | output | 1 | Data-phase line valid (one cycle) |
| dp_data | output | LINE_W | Buffered dirty line |
| lcl_fill | input | 1 | Own read fill completes for `lcl_addr` |
| lcl_wr | input | 1 | Own store to `lcl_addr` |
| lcl_addr | input | ADDR_W | Line address of the local operation |
| bus_hit_n | input | 1 | Combined clean-hit answer of other snoopers for the fill |
| bus_hitm_n | input | 1 | Combined modified-hit answer of other snoopers for the fill |

## Verification
Lines are brought into each of the four states through fills with every combination of the other agents' answers and through local stores. Each state is then snooped by reads and by writes, which separates the clean-hit, miss-with-invalidate and modified-hit paths. Follow-up snoops to the same line show the state that was left behind. A local store after a fill tells an Exclusive fill from a Shared one, and a same-set address with a different tag tells a tag compare from an index-only match. Ignored command codes are followed by a real snoop that proves nothing changed. Dirty lines are held with the controller idle for several cycles to show the stall and the withheld data phase before the release.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {RES_MISS = 2'd0, RES_CLEAN = 2'd1, RES_MOD = 2'd2} snp_res_t;
  localparam logic [1:0] CMD_RD = 2'b01;
  localparam logic [1:0] CMD_WR = 2'b10;
endpackage

// File: rtl/snp_decide.sv
module snp_decide
  import snp_pkg::*;
(
  input  logic     is_wr,
  input  line_st_t cur,
  output snp_res_t res,
  output line_st_t nxt
);
  always_comb begin
    res = RES_MISS;
    nxt = ST_I;
    case (cur)
      ST_M: begin
        res = RES_MOD;
        nxt = is_wr ? ST_I : ST_S;
      end
      ST_E, ST_S: begin
        res = is_wr ? RES_MISS : RES_CLEAN;
        nxt = is_wr ? ST_I : ST_S;
      end
      default: begin
        res = RES_MISS;
        nxt = ST_I;
      end
    endcase
  end
endmodule

// File: rtl/snp_tag_array.sv
module snp_tag_array
  import snp_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output logic [TAG_W-1:0] a_tag,
  output line_st_t         a_st,
  input  logic [IDX_W-1:0] b_idx,
  output logic [TAG_W-1:0] b_tag,
  output line_st_t         b_st,
  input  logic             s_we,
  input  logic [IDX_W-1:0] s_idx,
  input  line_st_t         s_st,
  input  logic             l_we,
  input  logic             l_tag_we,
  input  logic [IDX_W-1:0] l_idx,
  input  logic [TAG_W-1:0] l_tag,
  input  line_st_t         l_st
);
  line_st_t         st_q  [SETS];
  logic [TAG_W-1:0] tag_q [SETS];

  assign a_tag = tag_q[a_idx];
  assign a_st  = st_q[a_idx];
  assign b_tag = tag_q[b_idx];
  assign b_st  = st_q[b_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) st_q[i] <= ST_I;
    end else begin
      for (int i = 0; i < SETS; i++) begin
        if (s_we && s_idx == IDX_W'(i)) st_q[i] <= s_st;
        else if (l_we && l_idx == IDX_W'(i)) st_q[i] <= l_st;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SETS; i++) begin
      if (l_we && l_tag_we && l_idx == IDX_W'(i) && !(s_we && s_idx == IDX_W'(i)))
        tag_q[i] <= l_tag;
    end
  end
endmodule

// File: rtl/snp_wb_buf.sv
module snp_wb_buf #(
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [LINE_W-1:0] ld_data,
  input  logic              rdy,
  output logic              full,
  output logic              dp_valid,
  output logic [LINE_W-1:0] dp_data
);
  logic              full_q, full_d, dv_q, dv_d, send;
  logic [LINE_W-1:0] buf_q, dd_q;

  assign send = full_q && rdy;

  always_comb begin
    full_d = full_q;
    dv_d   = 1'b0;
    if (send) begin
      full_d = 1'b0;
      dv_d   = 1'b1;
    end
    if (ld) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      dv_q   <= 1'b0;
    end else begin
      full_q <= full_d;
      dv_q   <= dv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ld)   buf_q <= ld_data;
    if (send) dd_q  <= buf_q;
  end

  assign full     = full_q;
  assign dp_valid = dv_q;
  assign dp_data  = dd_q;

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n) ld |-> !full_q) // R9
    else $error("buffer loaded while full");
  AST_DP_ASKED: assert property (@(posedge clk) disable iff (!rst_n) dv_q |-> $past(rdy)) // R9
    else $error("data phase without request");
endmodule

// File: rtl/snp_responder.sv
module snp_responder
  import snp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SETS   = 4,
  parameter int LINE_W = 64,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_stall,
  output logic              snp_hit_n,
  output logic              snp_hitm_n,
  output logic [IDX_W-1:0]  arr_idx,
  input  logic [LINE_W-1:0] arr_data,
  input  logic              mc_rdy,
  output logic              dp_valid,
  output logic [LINE_W-1:0] dp_data,
  input  logic              lcl_fill,
  input  logic              lcl_wr,
  input  logic [ADDR_W-1:0] lcl_addr,
  input  logic              bus_hit_n,
  input  logic              bus_hitm_n
);
  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic              v1_q, v1_d, c1_q, c1_d, v2_q, v2_d;
  logic [ADDR_W-1:0] a1_q, a1_d;
  snp_res_t          r2_q, r2_d, res1;
  logic              hn_q, hn_d, hmn_q, hmn_d;
  logic              acc, a_hit, b_hit, wb_full, wb_ld;
  logic [TAG_W-1:0]  a_tag, b_tag;
  line_st_t          a_st, b_st, cur1, nxt1, l_st;
  logic              l_we;

  assign acc   = req_valid && !req_stall && (req_cmd == CMD_RD || req_cmd == CMD_WR);
  assign arr_idx = a1_q[IDX_W-1:0];
  assign a_hit = (a_st != ST_I) && (a_tag == a1_q[ADDR_W-1:IDX_W]);
  assign cur1  = a_hit ? a_st : ST_I;
  assign b_hit = (b_st != ST_I) && (b_tag == lcl_addr[ADDR_W-1:IDX_W]);

  snp_decide u_decide (
    .is_wr (c1_q),
    .cur   (cur1),
    .res   (res1),
    .nxt   (nxt1)
  );

  always_comb begin
    l_we = lcl_fill || (lcl_wr && b_hit && (b_st == ST_E || b_st == ST_M));
    if (lcl_fill) l_st = (bus_hit_n && bus_hitm_n) ? ST_E : ST_S;
    else          l_st = ST_M;
  end

  snp_tag_array #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_i),
    .a_idx    (a1_q[IDX_W-1:0]),
    .a_tag    (a_tag),
    .a_st     (a_st),
    .b_idx    (lcl_addr[IDX_W-1:0]),
    .b_tag    (b_tag),
    .b_st     (b_st),
    .s_we     (v1_q && a_hit),
    .s_idx    (a1_q[IDX_W-1:0]),
    .s_st     (nxt1),
    .l_we     (l_we),
    .l_tag_we (lcl_fill),
    .l_idx    (lcl_addr[IDX_W-1:0]),
    .l_tag    (lcl_addr[ADDR_W-1:IDX_W]),
    .l_st     (l_st)
  );

  assign wb_ld = v1_q && (res1 == RES_MOD);

  snp_wb_buf #(.LINE_W(LINE_W)) u_wb (
    .clk      (clk),
    .rst_n    (rst_i),
    .ld       (wb_ld),
    .ld_data  (arr_data),
    .rdy      (mc_rdy),
    .full     (wb_full),
    .dp_valid (dp_valid),
    .dp_data  (dp_data)
  );

  always_comb begin
    v1_d  = acc;
    a1_d  = acc ? req_addr : a1_q;
    c1_d  = acc ? (req_cmd == CMD_WR) : c1_q;
    v2_d  = v1_q;
    r2_d  = v1_q ? res1 : r2_q;
    hn_d  = !(v2_q && r2_q == RES_CLEAN);
    hmn_d = !(v2_q && r2_q == RES_MOD);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      v1_q  <= 1'b0;
      c1_q  <= 1'b0;
      a1_q  <= '0;
      v2_q  <= 1'b0;
      r2_q  <= RES_MISS;
      hn_q  <= 1'b1;
      hmn_q <= 1'b1;
    end else begin
      v1_q  <= v1_d;
      c1_q  <= c1_d;
      a1_q  <= a1_d;
      v2_q  <= v2_d;
      r2_q  <= r2_d;
      hn_q  <= hn_d;
      hmn_q <= hmn_d;
    end
  end

  assign req_stall  = v1_q || v2_q || wb_full;
  assign snp_hit_n  = hn_q;
  assign snp_hitm_n = hmn_q;

  AST_HIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_i) snp_hit_n || snp_hitm_n) // R2
    else $error("both snoop outputs low");
  AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (!rst_i)
    (!snp_hit_n || !snp_hitm_n) |-> $past(acc, 3)) // R3
    else $error("answer without a request three samples back");
  AST_WRITE_NO_CLEAN: assert property (@(posedge clk) disable iff (!rst_i)
    !snp_hit_n |-> !$past(c1_q, 2)) // R7
    else $error("clean hit answered to a write snoop");
  AST_FULL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_i)
    wb_full |=> !v1_q) // R9
    else $error("request taken while buffer full");
endmodule

// File: tb/snp_responder_tb.sv
`timescale 1ns/1ps
module snp_responder_tb;
  localparam int ADDR_W = 8;
  localparam int SETS   = 4;
  localparam int LINE_W = 64;
  localparam int IDX_W  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, mc_rdy = 0, lcl_fill = 0, lcl_wr = 0, bus_hit_n = 1, bus_hitm_n = 1;
  logic [1:0] req_cmd = 0;
  logic [ADDR_W-1:0] req_addr = 0, lcl_addr = 0;
  logic req_stall, snp_hit_n, snp_hitm_n, dp_valid;
  logic [IDX_W-1:0] arr_idx;
  logic [LINE_W-1:0] arr_data, dp_data;

  int checks = 0, errors = 0;
  bit chk_on = 0;

  always #2.5 clk = ~clk;

  function automatic logic [LINE_W-1:0] dat(int idx);
    logic [LINE_W-1:0] v;
    for (int b = 0; b < LINE_W / 8; b++) v[b*8 +: 8] = 8'(8'h5A + idx * 8'h13 + b);
    return v;
  endfunction

  assign arr_data = dat(int'(arr_idx));

  snp_responder #(.ADDR_W(ADDR_W), .SETS(SETS), .LINE_W(LINE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
    .req_stall(req_stall), .snp_hit_n(snp_hit_n), .snp_hitm_n(snp_hitm_n), .arr_idx(arr_idx),
    .arr_data(arr_data), .mc_rdy(mc_rdy), .dp_valid(dp_valid), .dp_data(dp_data),
    .lcl_fill(lcl_fill), .lcl_wr(lcl_wr), .lcl_addr(lcl_addr),
    .bus_hit_n(bus_hit_n), .bus_hitm_n(bus_hitm_n)
  );

  task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // reference model: states 0=I 1=S 2=E 3=M
  int m_st [SETS];
  int m_tag [SETS];
  int ph = 0, pend_res = 0;
  bit mbuf = 0, e_hit = 1, e_hitm = 1, e_dv = 0, e_stall = 0, stall_pre;
  logic [LINE_W-1:0] mbuf_data, pend_data, e_dd;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; mbuf = 0; e_hit = 1; e_hitm = 1; e_dv = 0; e_stall = 0;
      for (int i = 0; i < SETS; i++) begin m_st[i] = 0; m_tag[i] = -1; end
    end else begin
      int idx, tg;
      bit hit;
      stall_pre = (ph == 1 || ph == 2) || mbuf;
      e_dv = 0;
      if (mbuf && mc_rdy) begin e_dv = 1; e_dd = mbuf_data; mbuf = 0; end
      e_hit = 1; e_hitm = 1;
      if (ph == 1) begin
        ph = 2;
        if (pend_res == 2) begin mbuf = 1; mbuf_data = pend_data; end
      end else if (ph == 2) begin
        ph = 3; e_hit = !(pend_res == 1); e_hitm = !(pend_res == 2);
      end else if (ph == 3) ph = 0;
      idx = int'(lcl_addr) % SETS; tg = int'(lcl_addr) / SETS;
      hit = m_st[idx] != 0 && m_tag[idx] == tg;
      if (lcl_fill) begin
        m_tag[idx] = tg; m_st[idx] = (bus_hit_n && bus_hitm_n) ? 2 : 1;
      end else if (lcl_wr && hit && m_st[idx] >= 2) m_st[idx] = 3;
      if (req_valid && !stall_pre && (req_cmd == 2'b01 || req_cmd == 2'b10)) begin
        idx = int'(req_addr) % SETS; tg = int'(req_addr) / SETS;
        hit = m_st[idx] != 0 && m_tag[idx] == tg;
        pend_data = dat(idx);
        pend_res = 0;
        if (hit) begin
          if (m_st[idx] == 3) pend_res = 2;
          else if (req_cmd == 2'b01) pend_res = 1;
          m_st[idx] = (req_cmd == 2'b01) ? 1 : 0;
        end
        ph = 1;
      end
      e_stall = (ph == 1 || ph == 2) || mbuf;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      chk(snp_hit_n === e_hit, "R2", "cycle snp_hit_n", 64'(snp_hit_n), 64'(e_hit));
      chk(snp_hitm_n === e_hitm, "R3", "cycle snp_hitm_n", 64'(snp_hitm_n), 64'(e_hitm));
      chk(req_stall === e_stall, "R3", "cycle req_stall", 64'(req_stall), 64'(e_stall));
      chk(dp_valid === e_dv, "R9", "cycle dp_valid", 64'(dp_valid), 64'(e_dv));
      if (e_dv) chk(dp_data === e_dd, "R9", "cycle dp_data", dp_data, e_dd);
    end
  end

  // res: 0 miss, 1 clean, 2 modified
  task automatic snoop(logic [1:0] cmd, logic [ADDR_W-1:0] a, int exp, string rq);
    int got;
    while (req_stall) @(negedge clk);
    req_valid = 1; req_cmd = cmd; req_addr = a;
    @(negedge clk); req_valid = 0;
    @(negedge clk);
    @(negedge clk);
    got = (!snp_hit_n) ? 1 : (!snp_hitm_n) ? 2 : 0;
    chk(got == exp, rq, "snoop answer", 64'(got), 64'(exp));
    @(negedge clk);
  endtask

  task automatic lcl(bit fill, bit wr, logic [ADDR_W-1:0] a, bit bh, bit bhm);
    lcl_fill = fill; lcl_wr = wr; lcl_addr = a; bus_hit_n = bh; bus_hitm_n = bhm;
    @(negedge clk);
    lcl_fill = 0; lcl_wr = 0; bus_hit_n = 1; bus_hitm_n = 1;
  endtask

  task automatic drain(int idx, string rq);
    repeat (3) begin
      @(negedge clk);
      chk(req_stall === 1'b1, rq, "stall while holding", 64'(req_stall), 64'd1);
      chk(dp_valid === 1'b0, rq, "no data before request", 64'(dp_valid), 64'd0);
    end
    mc_rdy = 1;
    @(negedge clk); mc_rdy = 0;
    chk(dp_valid === 1'b1, rq, "data phase valid", 64'(dp_valid), 64'd1);
    chk(dp_data === dat(idx), rq, "data phase line", dp_data, dat(idx));
    @(negedge clk);
    chk(dp_valid === 1'b0 && req_stall === 1'b0, rq, "buffer emptied", 64'({dp_valid, req_stall}), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk_on = 1;
    chk(snp_hit_n && snp_hitm_n && !req_stall && !dp_valid, "R1", "reset outputs",
        64'({snp_hit_n, snp_hitm_n, req_stall, dp_valid}), 64'b1100);
    snoop(2'b01, 8'h05, 0, "R1");
    snoop(2'b10, 8'h16, 0, "R1");
    // E line: read -> clean, stays S
    lcl(1, 0, 8'h05, 1, 1);
    snoop(2'b01, 8'h05, 1, "R5");
    snoop(2'b01, 8'h05, 1, "R5");
    lcl(0, 1, 8'h05, 1, 1);
    snoop(2'b01, 8'h05, 1, "R11");
    snoop(2'b10, 8'h05, 0, "R7");
    snoop(2'b01, 8'h05, 0, "R7");
    // fill with other clean hit -> S, store has no effect
    lcl(1, 0, 8'h16, 0, 1);
    lcl(0, 1, 8'h16, 1, 1);
    snoop(2'b01, 8'h16, 1, "R10");
    // fill with other modified hit -> S
    lcl(1, 0, 8'h3A, 1, 0);
    lcl(0, 1, 8'h3A, 1, 1);
    snoop(2'b01, 8'h3A, 1, "R10");
    // E fill then store -> M, read snoop
    lcl(1, 0, 8'h09, 1, 1);
    lcl(0, 1, 8'h09, 1, 1);
    lcl(0, 1, 8'h09, 1, 1);
    snoop(2'b01, 8'h09, 2, "R6");
    drain(1, "R9");
    snoop(2'b01, 8'h09, 1, "R6");
    // write snoop on M
    lcl(1, 0, 8'h0B, 1, 1);
    lcl(0, 1, 8'h0B, 1, 1);
    snoop(2'b10, 8'h0B, 2, "R8");
    drain(3, "R8");
    snoop(2'b01, 8'h0B, 0, "R8");
    // E write snoop -> invalidate
    lcl(1, 0, 8'h08, 1, 1);
    snoop(2'b10, 8'h08, 0, "R7");
    lcl(0, 1, 8'h08, 1, 1);
    snoop(2'b01, 8'h08, 0, "R11");
    // tag mismatch in same set
    lcl(1, 0, 8'h05, 1, 1);
    snoop(2'b01, 8'h45, 0, "R5");
    snoop(2'b10, 8'h45, 0, "R5");
    snoop(2'b01, 8'h05, 1, "R5");
    // fill and store together -> fill wins (E)
    lcl(1, 1, 8'h0E, 1, 1);
    // ignored command codes
    for (int k = 0; k < 2; k++) begin
      req_valid = 1; req_cmd = (k == 0) ? 2'b00 : 2'b11; req_addr = 8'h0E;
      @(negedge clk); req_valid = 0;
      repeat (3) begin
        chk(snp_hit_n && snp_hitm_n && !req_stall, "R4", "ignored command",
            64'({snp_hit_n, snp_hitm_n, req_stall}), 64'b110);
        @(negedge clk);
      end
    end
    lcl(0, 1, 8'h0E, 1, 1);
    snoop(2'b10, 8'h0E, 2, "R4");
    drain(2, "R9");
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule